// File: doc/BRIEF.md
# Programmable Routing Switchbox

This block sits where a horizontal routing channel crosses a vertical one. Each of its four sides (north, east, south, west) has four unidirectional input tracks and four unidirectional output tracks. Configuration flip-flops decide which input track drives each output track. Once the configuration is loaded, the routing from inputs to outputs is purely combinational.

Each output track can be driven from the other three sides, and from each of those sides in one of two patterns. In the straight pattern the source is the input track with the same index. In the rotated pattern, input track i feeds output track (i+3) mod 4. That gives six switches per output and 96 switches in total, and each switch has its own configuration bit. The bits form one serial chain, loaded while a load-enable is high. While loading, the routing outputs are forced low. If more than one switch is enabled for the same output, a fixed priority picks the driver and a per-output conflict flag is raised.

Side numbers are north 0, east 1, south 2, west 3. Tracks are numbered 0 to 3.

Top module: `sbox_switchbox`

## Requirements
- R1: While rst_ni is low, and after it is released until a load occurs, every configuration bit is 0. All routing outputs, conflict_o and cfg_dout_o read 0.
- R2: On every rising clock edge with cfg_load_i high, the chain shifts one place toward its top bit, and cfg_din_i enters bit 0. cfg_dout_o always shows bit 95. A bit presented first therefore ends at bit 95 after 96 shifts, and cfg_dout_o replays the previous contents, top bit first.
- R3: While cfg_load_i is low, the configuration, cfg_dout_o and conflict_o hold their values, whatever cfg_din_i does.
- R4: While cfg_load_i is high, all routing outputs and all of conflict_o are 0.
- R5: Configuration bit ((D*4+T)*6 + C*2 + P) enables one switch into output track T of side D. C is the rank (0..2) of the source side among the three other sides, counted in ascending side number. P is 0 for the straight pattern and 1 for the rotated pattern.
- R6: A straight switch drives output track T of side D from input track T of the source side.
- R7: A rotated switch drives output track T of side D from input track (T+1) mod 4 of the source side. Equivalently, input track i reaches output track (i+3) mod 4.
- R8: An output track with no enabled switch reads 0.
- R9: When several switches into one output are enabled, the one with the lowest bit index in R5 drives it. The lower-numbered source side therefore wins, and within a side the straight switch wins over the rotated one.
- R10: Bit D*4+T of conflict_o is 1 exactly when two or more switches into output track T of side D are enabled and cfg_load_i is low.
- R11: With cfg_load_i low, a change on an input track reaches the routed outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration chain |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_load_i | input | 1 | Shift enable for the configuration chain; blanks the outputs while high |
| cfg_din_i | input | 1 | Serial configuration data in |
| cfg_dout_o | output | 1 | Serial configuration data out (top chain bit) |
| n_in_i | input | 4 | North input tracks |
| e_in_i | input | 4 | East input tracks |
| s_in_i | input | 4 | South input tracks |
| w_in_i | input | 4 | West input tracks |
| n_out_o | output | 4 | North output tracks |
| e_out_o | output | 4 | East output tracks |
| s_out_o | output | 4 | South output tracks |
| w_out_o | output | 4 | West output tracks |
| conflict_o | output | 16 | Per-output conflict flags, bit D*4+T |

## Verification
The hardest state to reach from the ports is two enabled switches competing for one output. This needs a full 96-bit serial load in which exactly the right pair of bits lands on the right chain positions, followed by input patterns that tell the two sources apart. The bench therefore sweeps every pair of the six switches behind each of the 16 outputs. For each pair it loads the chain and then walks a single 1 across all 16 input tracks, so the winning source and the conflict flag are exposed separately. The readback of the chain is checked by reloading it and comparing cfg_dout_o against the previous image, bit by bit.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int unsigned SIDES    = 4;
  localparam int unsigned CANDS    = SIDES - 1;
  localparam int unsigned PATTERNS = 2;
  localparam int unsigned SLOTS    = CANDS * PATTERNS;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  typedef enum logic {
    PAT_STRAIGHT = 1'b0,
    PAT_ROTATED  = 1'b1
  } pat_e;

  // source side of candidate rank cand for an output on side dst
  function automatic int unsigned src_side(int unsigned dst, int unsigned cand);
    return (cand < dst) ? cand : cand + 1;
  endfunction

  // rotated: input i feeds output (i+TRACKS-1) mod TRACKS
  function automatic int unsigned src_track(int unsigned dst_trk, int unsigned pat,
                                            int unsigned tracks);
    return (pat == 0) ? dst_trk : (dst_trk + 1) % tracks;
  endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
  parameter int unsigned NBITS = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [NBITS-1:0] cfg_o,
  output logic             dout_o
);

  logic [NBITS-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (shift_i) chain_q <= {chain_q[NBITS-2:0], din_i};
  end

  assign cfg_o  = chain_q;
  assign dout_o = chain_q[NBITS-1];

endmodule

// File: rtl/sbox_out_sel.sv
module sbox_out_sel #(
  parameter int unsigned SLOTS = 6
) (
  input  logic [SLOTS-1:0] cand_i,
  input  logic [SLOTS-1:0] en_i,
  input  logic             blank_i,
  output logic             out_o,
  output logic             conflict_o
);

  logic pick;
  logic found;
  logic multi;

  // lowest slot index wins
  always_comb begin
    pick  = 1'b0;
    found = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (en_i[k] && !found) begin
        pick  = cand_i[k];
        found = 1'b1;
      end
    end
  end

  // two or more bits set: clearing the lowest set bit leaves something
  assign multi = |(en_i & (en_i - SLOTS'(1)));

  assign out_o      = pick  & ~blank_i;
  assign conflict_o = multi & ~blank_i;

endmodule

// File: rtl/sbox_switchbox.sv
module sbox_switchbox
  import sbox_pkg::*;
#(
  parameter int unsigned TRACKS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_load_i,
  input  logic                       cfg_din_i,
  output logic                       cfg_dout_o,
  input  logic [TRACKS-1:0]          n_in_i,
  input  logic [TRACKS-1:0]          e_in_i,
  input  logic [TRACKS-1:0]          s_in_i,
  input  logic [TRACKS-1:0]          w_in_i,
  output logic [TRACKS-1:0]          n_out_o,
  output logic [TRACKS-1:0]          e_out_o,
  output logic [TRACKS-1:0]          s_out_o,
  output logic [TRACKS-1:0]          w_out_o,
  output logic [SIDES*TRACKS-1:0]    conflict_o
);

  localparam int unsigned NIO  = SIDES * TRACKS;
  localparam int unsigned NCFG = NIO * SLOTS;

  logic [NIO-1:0]  in_flat;
  logic [NIO-1:0]  out_flat;
  logic [NCFG-1:0] cfg;

  assign in_flat = {w_in_i, s_in_i, e_in_i, n_in_i};
  assign n_out_o = out_flat[SIDE_N*TRACKS +: TRACKS];
  assign e_out_o = out_flat[SIDE_E*TRACKS +: TRACKS];
  assign s_out_o = out_flat[SIDE_S*TRACKS +: TRACKS];
  assign w_out_o = out_flat[SIDE_W*TRACKS +: TRACKS];

  sbox_cfg_chain #(.NBITS(NCFG)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (cfg_load_i),
    .din_i   (cfg_din_i),
    .cfg_o   (cfg),
    .dout_o  (cfg_dout_o)
  );

  for (genvar d = 0; d < SIDES; d++) begin : g_side
    for (genvar t = 0; t < TRACKS; t++) begin : g_trk
      localparam int unsigned OIDX = d * TRACKS + t;
      logic [SLOTS-1:0] cand;

      for (genvar c = 0; c < CANDS; c++) begin : g_cand
        for (genvar p = 0; p < PATTERNS; p++) begin : g_pat
          localparam int unsigned SIDX = src_side(d, c) * TRACKS + src_track(t, p, TRACKS);
          assign cand[c*PATTERNS+p] = in_flat[SIDX];
        end
      end

      sbox_out_sel #(.SLOTS(SLOTS)) u_sel (
        .cand_i     (cand),
        .en_i       (cfg[OIDX*SLOTS +: SLOTS]),
        .blank_i    (cfg_load_i),
        .out_o      (out_flat[OIDX]),
        .conflict_o (conflict_o[OIDX])
      );
    end
  end

endmodule

// File: rtl/sbox_switchbox_chk.sv
module sbox_switchbox_chk #(
  parameter int unsigned TRACKS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_load_i,
  input logic                cfg_dout_o,
  input logic [TRACKS-1:0]   n_in_i,
  input logic [TRACKS-1:0]   e_in_i,
  input logic [TRACKS-1:0]   s_in_i,
  input logic [TRACKS-1:0]   w_in_i,
  input logic [TRACKS-1:0]   n_out_o,
  input logic [TRACKS-1:0]   e_out_o,
  input logic [TRACKS-1:0]   s_out_o,
  input logic [TRACKS-1:0]   w_out_o,
  input logic [4*TRACKS-1:0] conflict_o
);

  logic [4*TRACKS-1:0] ins;
  logic [4*TRACKS-1:0] outs;

  assign ins  = {w_in_i, s_in_i, e_in_i, n_in_i};
  assign outs = {w_out_o, s_out_o, e_out_o, n_out_o};

  // R4
  load_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |-> (outs == '0 && conflict_o == '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && ins == '0) |-> outs == '0);

  // R3
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_load_i) |-> $stable(cfg_dout_o));

  // R3
  conflict_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_load_i) && !cfg_load_i) |-> $stable(conflict_o));

endmodule

bind sbox_switchbox sbox_switchbox_chk #(.TRACKS(TRACKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .cfg_dout_o (cfg_dout_o),
  .n_in_i     (n_in_i),
  .e_in_i     (e_in_i),
  .s_in_i     (s_in_i),
  .w_in_i     (w_in_i),
  .n_out_o    (n_out_o),
  .e_out_o    (e_out_o),
  .s_out_o    (s_out_o),
  .w_out_o    (w_out_o),
  .conflict_o (conflict_o)
);

// File: tb/sbox_switchbox_test.sv
module sbox_switchbox_test;

  localparam int CLK_PERIOD = 10;
  localparam int TRK  = 4;
  localparam int NIO  = 16;
  localparam int NSL  = 6;
  localparam int NCFG = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic din = 1'b0;
  logic dout;
  logic [NIO-1:0] ins = '0;
  logic [TRK-1:0] n_out, e_out, s_out, w_out;
  logic [NIO-1:0] conf;
  logic [NIO-1:0] outs;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbox_switchbox #(.TRACKS(TRK)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_load_i (load),
    .cfg_din_i  (din),
    .cfg_dout_o (dout),
    .n_in_i     (ins[3:0]),
    .e_in_i     (ins[7:4]),
    .s_in_i     (ins[11:8]),
    .w_in_i     (ins[15:12]),
    .n_out_o    (n_out),
    .e_out_o    (e_out),
    .s_out_o    (s_out),
    .w_out_o    (w_out),
    .conflict_o (conf)
  );

  assign outs = {w_out, s_out, e_out, n_out};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // expected routing from the bit layout, side order and priority rules
  function automatic void model(input logic [NCFG-1:0] c, input logic [NIO-1:0] x,
                                output logic [NIO-1:0] o, output logic [NIO-1:0] f);
    o = '0;
    f = '0;
    for (int d = 0; d < 4; d++) begin
      for (int t = 0; t < TRK; t++) begin
        int cnt = 0;
        for (int sl = 0; sl < NSL; sl++) begin
          int rk = sl / 2;
          int src = (rk < d) ? rk : rk + 1;
          int tr = (sl % 2 == 1) ? (t + 1) % TRK : t;
          if (c[(d*TRK+t)*NSL+sl]) begin
            cnt++;
            if (cnt == 1) o[d*TRK+t] = x[src*TRK+tr];
          end
        end
        f[d*TRK+t] = (cnt > 1);
      end
    end
  endfunction

  // shift v in top bit first; optionally compare readback against prev
  task automatic load_cfg(input logic [NCFG-1:0] v, input bit chk_rb,
                          input logic [NCFG-1:0] prev);
    @(negedge clk);
    load = 1'b1;
    for (int i = NCFG - 1; i >= 0; i--) begin
      din = v[i];
      if (chk_rb) begin
        #1;
        // R2 readback of previous image
        check("R2 dout", 32'(dout), 32'(prev[i]));
        if (i == 48) begin
          ins = '1;
          #1;
          // R4 blanking mid-load
          check("R4 outs", 32'(outs), 32'h0);
          check("R4 conflict", 32'(conf), 32'h0);
        end
      end
      @(negedge clk);
    end
    load = 1'b0;
    din = 1'b0;
  endtask

  task automatic check_routes(input string req, input logic [NCFG-1:0] c,
                              input logic [NIO-1:0] pat);
    logic [NIO-1:0] eo, ef;
    @(negedge clk);
    ins = pat;
    #1;
    model(c, pat, eo, ef);
    check(req, 32'(outs), 32'(eo));
    check("R10 conflict", 32'(conf), 32'(ef));
  endtask

  task automatic sweep_inputs(input string req, input logic [NCFG-1:0] c);
    for (int k = 0; k < NIO; k++) check_routes(req, c, NIO'(1) << k);
    check_routes(req, c, '1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [NCFG-1:0] c, v1, v2;
    logic [NIO-1:0] eo, ef;

    // R1 reset state
    ins = 16'hA5C3;
    repeat (3) @(negedge clk);
    check("R1 outs in reset", 32'(outs), 32'h0);
    check("R1 conflict in reset", 32'(conf), 32'h0);
    check("R1 dout in reset", 32'(dout), 32'h0);
    rst_n = 1'b1;
    // R8 nothing enabled after reset
    check_routes("R8 empty config", '0, '1);
    check_routes("R8 empty config", '0, 16'h3C96);

    // single switch sweep: R5 layout, R6 straight, R7 rotated
    for (int b = 0; b < NCFG; b++) begin
      c = NCFG'(1) << b;
      load_cfg(c, 1'b0, '0);
      sweep_inputs((b % 2 == 1) ? "R7 rotated" : "R6 straight", c);
    end

    // R9 priority and R10 conflict over every pair behind every output
    for (int o = 0; o < NIO; o++) begin
      for (int a = 0; a < NSL; a++) begin
        for (int b = a + 1; b < NSL; b++) begin
          c = '0;
          c[o*NSL+a] = 1'b1;
          c[o*NSL+b] = 1'b1;
          load_cfg(c, 1'b0, '0);
          sweep_inputs("R9 priority", c);
        end
      end
    end

    // R5 random full configurations
    for (int r = 0; r < 20; r++) begin
      c = {$urandom, $urandom, $urandom};
      load_cfg(c, 1'b0, '0);
      for (int k = 0; k < 6; k++) check_routes("R5 random", c, NIO'($urandom));
    end

    // R2 readback and R4 blanking
    v1 = {$urandom, $urandom, $urandom};
    v2 = {$urandom, $urandom, $urandom};
    load_cfg(v1, 1'b0, '0);
    load_cfg(v2, 1'b1, v1);
    check_routes("R2 new image", v2, 16'hF0F0);

    // R3 hold while load low and din toggles
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      din = 1'($urandom);
    end
    check_routes("R3 hold", v2, 16'h5A5A);
    check("R3 dout hold", 32'(dout), 32'(v2[NCFG-1]));

    // R11 combinational path, no clock edge between changes
    @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      ins = NIO'($urandom);
      #1;
      model(v2, ins, eo, ef);
      check("R11 comb", 32'(outs), 32'(eo));
    end

    // R1 asynchronous reset mid-run
    @(negedge clk);
    ins = '1;
    rst_n = 1'b0;
    #1;
    check("R1 async outs", 32'(outs), 32'h0);
    check("R1 async dout", 32'(dout), 32'h0);
    check("R1 async conflict", 32'(conf), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule